// File: doc/BRIEF.md
# Staged Store-Load Dependency Checker

This block is the store queue of a load/store unit, together with the logic that decides how a load relates to the older stores still waiting in it. Each store first takes a slot in program order. Its address and its data are then written into that slot by two independent operations that may arrive in either order. Stores leave the queue oldest first through a retire strobe. The queue is split into equal partitions, one for each hardware thread. Each partition is a circular ring with head and tail pointers and a full flag.

A load is checked only against the stores of its own thread. The check runs in three narrowing stages. The first stage compares the 12-bit page offset. The second compares a partial physical field, bits [19:12]. The third compares the remaining upper bits, but only for stores whose full physical address is known; a store without one is taken as a match. The search starts at the youngest store and moves toward older ones, and the first store that survives all three stages wins. The winner forwards its data if that data has been written. Otherwise the load is blocked. A load that finds no winner is independent. Because the partial field can alias, a store with an unknown full address produces a false hit.

Top module: `stq_dep_check`

## Requirements
- R1: After reset every partition is empty and `alloc_rdy` is 1. An accepted allocation returns `alloc_idx` = thread × PART + slot, and successive allocations of one thread take consecutive slots starting at the partition base. Address writes and data writes reach an entry separately, by index.
- R2: A retire frees the oldest entry of the named thread. A retire to an empty partition changes nothing, so the next allocation index is not altered by it.
- R3: A load whose bits [11:0] differ from those of every eligible older store is reported independent (`res_kind` = 0).
- R4: A store that matches on bits [11:0] but differs on bits [19:12] does not match the load.
- R5: For a store whose full address is known, bits [PAW-1:20] must also match. A store written with `sta_pa_known` = 0 is taken as matching once bits [19:0] match.
- R6: Among the matching stores of the thread, the youngest wins and its index is reported.
- R7: With NUM_THR threads each thread owns PART = DEPTH/NUM_THR consecutive indices. A load is compared only with stores of its own `ld_tid`.
- R8: The winner yields forward (`res_kind` = 1) with its data when its data has been written, and block (`res_kind` = 2) with `res_data` = 0 otherwise. Code 3 never appears.
- R9: While a partition holds PART stores, `alloc_rdy` for that thread is 0 and an allocation request leaves the partition unchanged.
- R10: `res_vld` rises exactly one cycle after `ld_vld` and at no other time. An independent result carries `res_idx` = 0 and `res_data` = 0.
- R11: An allocated entry whose address has not yet been written takes no part in the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_vld | input | 1 | Request a store slot |
| alloc_tid | input | TIDW | Thread of the allocating store |
| alloc_rdy | output | 1 | Partition of `alloc_tid` has room |
| alloc_idx | output | IDXW | Index given to the allocating store |
| sta_vld | input | 1 | Store address write |
| sta_idx | input | IDXW | Entry written by the address write |
| sta_addr | input | PAW | Store address (offset, partial field, upper bits) |
| sta_pa_known | input | 1 | Upper bits of `sta_addr` are final |
| std_vld | input | 1 | Store data write |
| std_idx | input | IDXW | Entry written by the data write |
| std_data | input | DW | Store data |
| ret_vld | input | 1 | Retire oldest store of `ret_tid` |
| ret_tid | input | TIDW | Thread whose oldest store retires |
| ld_vld | input | 1 | Load check request |
| ld_tid | input | TIDW | Thread of the load |
| ld_addr | input | PAW | Load address |
| res_vld | output | 1 | Result valid, one cycle after request |
| res_kind | output | 2 | 0 independent, 1 forward, 2 block |
| res_idx | output | IDXW | Index of the winning store |
| res_data | output | DW | Forwarded data |

## Verification
Loads are issued against a set of stores that is grown step by step. The addresses are chosen so that each stage is the one that decides the outcome. An offset mismatch tests the first stage. An offset-only alias tests the partial field. A known upper mismatch and an unknown-address partial alias tell the final stage apart from its fallback rule. Two matching stores, one of them without data, show the youngest-first order and the choice between forward and block. An entry with no address written, loads from the other thread, retire down to an empty ring and a fill to full with a stalled allocation and a wrap cover ownership and pointer behaviour.

// File: rtl/stq_pkg.sv
// Shared types for the store queue dependency checker.
// Assumes page offset is bits [11:0] and the partial field is bits [19:12].
package stq_pkg;
    localparam int OFF_W  = 12;
    localparam int PART_W = 8;
    localparam int HI_LSB = OFF_W + PART_W;

    typedef enum logic [1:0] {
        DEP_NONE  = 2'd0,
        DEP_FWD   = 2'd1,
        DEP_BLOCK = 2'd2
    } dep_kind_e;
endpackage

// File: rtl/stq_cmp.sv
// Three-stage compare of one store entry against a load address.
// Assumes the entry fields are stable during the cycle of the check.
module stq_cmp import stq_pkg::*; #(
    parameter int PAW = 40
) (
    input  logic                  e_live,
    input  logic [OFF_W-1:0]      e_off,
    input  logic [PART_W-1:0]     e_part,
    input  logic [PAW-HI_LSB-1:0] e_hi,
    input  logic                  e_known,
    input  logic [PAW-1:0]        ld_addr,
    output logic                  hit
);
    logic s1, s2, s3;

    // Stage checks narrow from offset to partial field to full address.
    always_comb begin
        s1  = e_live && (e_off == ld_addr[OFF_W-1:0]);
        s2  = s1 && (e_part == ld_addr[HI_LSB-1:OFF_W]);
        s3  = s2 && (!e_known || (e_hi == ld_addr[PAW-1:HI_LSB]));
        hit = s3;
    end
endmodule

// File: rtl/stq_ring.sv
// One thread's partition: circular store ring plus youngest-first search.
// Assumes the caller gates allocation with the full flag it reports.
module stq_ring import stq_pkg::*; #(
    parameter int PART = 28,
    parameter int PAW  = 40,
    parameter int DW   = 64,
    localparam int SLOTW = $clog2(PART)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             sta_en,
    input  logic [SLOTW-1:0] sta_slot,
    input  logic [PAW-1:0]   sta_addr,
    input  logic             sta_known,
    input  logic             std_en,
    input  logic [SLOTW-1:0] std_slot,
    input  logic [DW-1:0]    std_data,
    input  logic             ret_en,
    input  logic [PAW-1:0]   ld_addr,
    output logic [SLOTW-1:0] tail_o,
    output logic             full_o,
    output logic [SLOTW:0]   occ_o,
    output dep_kind_e        hit_kind,
    output logic [SLOTW-1:0] hit_slot,
    output logic [DW-1:0]    hit_data
);
    logic [SLOTW-1:0] head, tail;
    logic             full, empty;
    logic [PART-1:0]  vld, aok, dok, known, hit;
    logic [OFF_W-1:0]      off  [PART];
    logic [PART_W-1:0]     prt  [PART];
    logic [PAW-HI_LSB-1:0] hi   [PART];
    logic [DW-1:0]         dat  [PART];

    function automatic logic [SLOTW-1:0] bump(input logic [SLOTW-1:0] p);
        return (int'(p) == PART - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty  = (head == tail) && !full;
    assign tail_o = tail;
    assign full_o = full;

    // Occupancy derived from pointers and the full flag.
    always_comb begin
        if (full)
            occ_o = (SLOTW+1)'(PART);
        else if (tail >= head)
            occ_o = (SLOTW+1)'(int'(tail) - int'(head));
        else
            occ_o = (SLOTW+1)'(PART + int'(tail) - int'(head));
    end

    // Pointer, full flag and per-entry status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0; tail <= '0; full <= 1'b0;
            vld <= '0; aok <= '0; dok <= '0; known <= '0;
        end else begin
            if (ret_en && !empty) begin
                vld[head] <= 1'b0;
                head      <= bump(head);
            end
            if (alloc_en && !full) begin
                vld[tail] <= 1'b1;
                aok[tail] <= 1'b0;
                dok[tail] <= 1'b0;
                tail      <= bump(tail);
            end
            if (sta_en) begin
                aok[sta_slot]   <= 1'b1;
                known[sta_slot] <= sta_known;
            end
            if (std_en)
                dok[std_slot] <= 1'b1;
            if ((alloc_en && !full) && !(ret_en && !empty))
                full <= (bump(tail) == head);
            else if (ret_en && !empty && !(alloc_en && !full))
                full <= 1'b0;
        end
    end

    // Address and data payload, no reset needed.
    always_ff @(posedge clk) begin
        if (sta_en) begin
            off[sta_slot] <= sta_addr[OFF_W-1:0];
            prt[sta_slot] <= sta_addr[HI_LSB-1:OFF_W];
            hi[sta_slot]  <= sta_addr[PAW-1:HI_LSB];
        end
        if (std_en)
            dat[std_slot] <= std_data;
    end

    for (genvar i = 0; i < PART; i++) begin : g_cmp
        stq_cmp #(.PAW(PAW)) u_cmp (
            .e_live (vld[i] && aok[i]),
            .e_off  (off[i]),
            .e_part (prt[i]),
            .e_hi   (hi[i]),
            .e_known(known[i]),
            .ld_addr(ld_addr),
            .hit    (hit[i])
        );
    end

    // Walk from youngest to oldest; first hit decides the outcome.
    always_comb begin
        int  s;
        logic found;
        found    = 1'b0;
        hit_kind = DEP_NONE;
        hit_slot = '0;
        hit_data = '0;
        for (int k = 0; k < PART; k++) begin
            s = int'(tail) - 1 - k;
            if (s < 0) s = s + PART;
            if (!found && (k < int'(occ_o)) && hit[s]) begin
                found    = 1'b1;
                hit_slot = SLOTW'(s);
                hit_kind = dok[s] ? DEP_FWD : DEP_BLOCK;
                hit_data = dok[s] ? dat[s] : '0;
            end
        end
    end
endmodule

// File: rtl/stq_dep_check.sv
// Top: per-thread store rings, index decode and registered load result.
// Assumes DEPTH divides evenly by NUM_THR and PAW is above 20 bits.
module stq_dep_check import stq_pkg::*; #(
    parameter int DEPTH   = 56,
    parameter int NUM_THR = 2,
    parameter int PAW     = 40,
    parameter int DW      = 64,
    localparam int IDXW   = $clog2(DEPTH),
    localparam int TIDW   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_vld,
    input  logic [TIDW-1:0] alloc_tid,
    output logic            alloc_rdy,
    output logic [IDXW-1:0] alloc_idx,
    input  logic            sta_vld,
    input  logic [IDXW-1:0] sta_idx,
    input  logic [PAW-1:0]  sta_addr,
    input  logic            sta_pa_known,
    input  logic            std_vld,
    input  logic [IDXW-1:0] std_idx,
    input  logic [DW-1:0]   std_data,
    input  logic            ret_vld,
    input  logic [TIDW-1:0] ret_tid,
    input  logic            ld_vld,
    input  logic [TIDW-1:0] ld_tid,
    input  logic [PAW-1:0]  ld_addr,
    output logic            res_vld,
    output logic [1:0]      res_kind,
    output logic [IDXW-1:0] res_idx,
    output logic [DW-1:0]   res_data
);
    localparam int PART  = DEPTH / NUM_THR;
    localparam int SLOTW = $clog2(PART);

    logic [NUM_THR-1:0][SLOTW-1:0] thr_tail, thr_hslot;
    logic [NUM_THR-1:0][SLOTW:0]   thr_occ;
    logic [NUM_THR-1:0][DW-1:0]    thr_hdata;
    logic [NUM_THR-1:0]            thr_full;
    dep_kind_e                     thr_kind [NUM_THR];
    dep_kind_e                     kind_q;

    assign alloc_rdy = !thr_full[alloc_tid];
    assign alloc_idx = IDXW'(int'(alloc_tid) * PART + int'(thr_tail[alloc_tid]));
    assign res_kind  = kind_q;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        localparam int BASE = t * PART;
        logic a_en, sa_en, sd_en, r_en;
        assign a_en  = alloc_vld && (int'(alloc_tid) == t);
        assign r_en  = ret_vld && (int'(ret_tid) == t);
        assign sa_en = sta_vld && (int'(sta_idx) >= BASE) && (int'(sta_idx) < BASE + PART);
        assign sd_en = std_vld && (int'(std_idx) >= BASE) && (int'(std_idx) < BASE + PART);

        stq_ring #(.PART(PART), .PAW(PAW), .DW(DW)) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_en (a_en),
            .sta_en   (sa_en),
            .sta_slot (SLOTW'(int'(sta_idx) - BASE)),
            .sta_addr (sta_addr),
            .sta_known(sta_pa_known),
            .std_en   (sd_en),
            .std_slot (SLOTW'(int'(std_idx) - BASE)),
            .std_data (std_data),
            .ret_en   (r_en),
            .ld_addr  (ld_addr),
            .tail_o   (thr_tail[t]),
            .full_o   (thr_full[t]),
            .occ_o    (thr_occ[t]),
            .hit_kind (thr_kind[t]),
            .hit_slot (thr_hslot[t]),
            .hit_data (thr_hdata[t])
        );
    end

    // Capture the selected thread's verdict one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            kind_q   <= DEP_NONE;
            res_idx  <= '0;
            res_data <= '0;
        end else begin
            res_vld <= ld_vld;
            if (ld_vld) begin
                kind_q   <= thr_kind[ld_tid];
                res_data <= thr_hdata[ld_tid];
                res_idx  <= (thr_kind[ld_tid] == DEP_NONE) ? '0 :
                            IDXW'(int'(ld_tid) * PART + int'(thr_hslot[ld_tid]));
            end
        end
    end
endmodule

// File: rtl/stq_dep_check_chk.sv
// Checker for the store queue dependency checker, bound to the top.
// Assumes it sees the top's ports and the per-thread occupancy vector.
module stq_dep_check_chk #(
    parameter int NUM_THR = 2,
    parameter int PART    = 28,
    parameter int IDXW    = 6,
    parameter int TIDW    = 1,
    parameter int OCCW    = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ld_vld,
    input logic [TIDW-1:0]               ld_tid,
    input logic                          res_vld,
    input logic [1:0]                    res_kind,
    input logic [IDXW-1:0]               res_idx,
    input logic [NUM_THR-1:0][OCCW-1:0]  occ
);
    assert_res_follows_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |=> res_vld);

    assert_res_needs_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(ld_vld));

    assert_indep_idx_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == 2'd0) |-> (res_idx == '0));

    assert_kind_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_kind != 2'd3));

    assert_own_partition_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind != 2'd0) |-> ((int'(res_idx) / PART) == int'($past(ld_tid))));

    for (genvar t = 0; t < NUM_THR; t++) begin : g_occ
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            int'(occ[t]) <= PART);
    end
endmodule

bind stq_dep_check stq_dep_check_chk #(
    .NUM_THR(NUM_THR),
    .PART   (DEPTH / NUM_THR),
    .IDXW   (IDXW),
    .TIDW   (TIDW),
    .OCCW   ($clog2(DEPTH / NUM_THR) + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_vld  (ld_vld),
    .ld_tid  (ld_tid),
    .res_vld (res_vld),
    .res_kind(res_kind),
    .res_idx (res_idx),
    .occ     (thr_occ)
);

// File: tb/stq_dep_check_test.sv
// Directed bench for the store queue dependency checker.
module stq_dep_check_test;
    localparam int DEPTH = 56, NUM_THR = 2, PAW = 40, DW = 64;
    localparam int PART = DEPTH / NUM_THR;
    localparam int IDXW = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_vld = 0, alloc_rdy;
    logic [0:0] alloc_tid = 0, ret_tid = 0, ld_tid = 0;
    logic [IDXW-1:0] alloc_idx, sta_idx = 0, std_idx = 0, res_idx;
    logic sta_vld = 0, sta_pa_known = 0, std_vld = 0, ret_vld = 0, ld_vld = 0, res_vld;
    logic [PAW-1:0] sta_addr = 0, ld_addr = 0;
    logic [DW-1:0] std_data = 0, res_data;
    logic [1:0] res_kind;

    int checks = 0, errors = 0;

    localparam logic [PAW-1:0] A = 40'h000ABCD123;

    stq_dep_check #(.DEPTH(DEPTH), .NUM_THR(NUM_THR), .PAW(PAW), .DW(DW)) uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    task automatic do_alloc(input int tid, output int idx, output bit rdy);
        @(negedge clk);
        alloc_vld = 1; alloc_tid = tid[0:0];
        #1; idx = int'(alloc_idx); rdy = alloc_rdy;
        @(negedge clk);
        alloc_vld = 0;
    endtask

    task automatic do_sta(input int idx, input logic [PAW-1:0] a, input bit kn);
        @(negedge clk);
        sta_vld = 1; sta_idx = IDXW'(idx); sta_addr = a; sta_pa_known = kn;
        @(negedge clk);
        sta_vld = 0;
    endtask

    task automatic do_std(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        std_vld = 1; std_idx = IDXW'(idx); std_data = d;
        @(negedge clk);
        std_vld = 0;
    endtask

    task automatic do_ret(input int tid);
        @(negedge clk);
        ret_vld = 1; ret_tid = tid[0:0];
        @(negedge clk);
        ret_vld = 0;
    endtask

    task automatic do_load(input int tid, input logic [PAW-1:0] a, input int ek,
                           input int ei, input logic [DW-1:0] ed, input string req);
        @(negedge clk);
        ld_vld = 1; ld_tid = tid[0:0]; ld_addr = a;
        @(negedge clk);
        ld_vld = 0;
        chk(res_vld === 1'b1 && int'(res_kind) == ek && int'(res_idx) == ei && res_data === ed, req,
            $sformatf("load %h: got vld=%0b kind=%0d idx=%0d data=%h, want vld=1 kind=%0d idx=%0d data=%h",
                      a, res_vld, res_kind, res_idx, res_data, ek, ei, ed));
        @(negedge clk);
        chk(res_vld === 1'b0, "R10", $sformatf("res_vld lingered: got %0b want 0", res_vld));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(alloc_rdy === 1'b1 && res_vld === 1'b0 && alloc_idx == '0, "R1",
            $sformatf("reset: rdy=%0b vld=%0b idx=%0d, want 1 0 0", alloc_rdy, res_vld, alloc_idx));
    endtask

    task automatic t_stages;
        int idx; bit rdy;
        do_alloc(0, idx, rdy);
        chk(idx == 0 && rdy, "R1", $sformatf("first slot got %0d want 0", idx));
        do_sta(0, A, 1'b1);
        do_std(0, 64'hD0D0);
        do_load(0, A, 1, 0, 64'hD0D0, "R5 full match forwards (R8)");
        do_load(0, A + 1, 0, 0, 0, "R3 offset mismatch");
        do_load(0, 40'h000AB11123, 0, 0, 0, "R4 partial field mismatch");
        do_load(0, 40'h0FFFFCD123, 0, 0, 0, "R5 known upper mismatch");
    endtask

    task automatic t_order;
        int idx; bit rdy;
        do_alloc(0, idx, rdy);
        chk(idx == 1, "R1", $sformatf("second slot got %0d want 1", idx));
        do_sta(1, A, 1'b1);
        do_load(0, A, 2, 1, 0, "R6 youngest wins, R8 no data blocks");
        do_alloc(0, idx, rdy);
        chk(idx == 2, "R1", $sformatf("third slot got %0d want 2", idx));
        do_load(0, A, 2, 1, 0, "R11 unwritten address skipped");
        do_std(2, 64'hD2D2);
        do_load(0, A, 2, 1, 0, "R11 data alone does not enable a match");
        do_sta(2, 40'h0555ACD123, 1'b0);
        do_load(0, A, 1, 2, 64'hD2D2, "R5 unknown address treated as match");
    endtask

    task automatic t_thread;
        int idx; bit rdy;
        do_alloc(1, idx, rdy);
        chk(idx == PART, "R7", $sformatf("thread 1 base got %0d want %0d", idx, PART));
        do_load(1, A, 0, 0, 0, "R7 other thread ignored");
        do_sta(PART, A, 1'b1);
        do_std(PART, 64'hE1E1);
        do_load(1, A, 1, PART, 64'hE1E1, "R7 own thread forward");
        do_load(0, A, 1, 2, 64'hD2D2, "R7 thread 0 unaffected");
    endtask

    task automatic t_retire;
        int idx; bit rdy;
        do_ret(0);
        do_ret(0);
        do_load(0, A, 1, 2, 64'hD2D2, "R2 oldest two retired, youngest remains");
        do_ret(0);
        do_load(0, A, 0, 0, 0, "R2 empty partition");
        do_ret(0);
        do_alloc(0, idx, rdy);
        chk(idx == 3 && rdy, "R2", $sformatf("after empty retire got %0d want 3", idx));
    endtask

    task automatic t_full;
        int idx; bit rdy; bit seq_ok;
        seq_ok = 1;
        for (int k = 1; k < PART; k++) begin
            do_alloc(1, idx, rdy);
            if (idx != PART + k || !rdy) seq_ok = 0;
        end
        chk(seq_ok, "R1", "thread 1 fill indices not consecutive");
        do_alloc(1, idx, rdy);
        chk(!rdy, "R9", $sformatf("full partition rdy got %0b want 0", rdy));
        do_ret(1);
        do_alloc(1, idx, rdy);
        chk(rdy && idx == PART, "R9", $sformatf("wrap slot got %0d want %0d", idx, PART));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_stages();
        t_order();
        t_thread();
        t_retire();
        t_full();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout want completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule